// File: doc/BRIEF.md
# Stop-Mode Wake-Up Sequencer

This block steers a small processor core into and out of a low-power stop state. When the core raises a stop request while the RC-watchdog select bit is set, the block turns off the main oscillator enable, gates the core clock, and freezes the port registers. The RC watchdog clock domain keeps running during the stop state. A stop request with the select bit clear is ignored.

The stop state ends on only two events: an external interrupt or an external hardware reset. An interrupt wake turns the oscillator on again and runs an 8-bit stabilization counter from zero. The counter steps once per group of prescaled ticks, and the group size is latched at stop entry. When the counter overflows, the block issues a one-cycle resume pulse with an action code. The code comes from the global interrupt flag, from any watchdog event seen while stopped, from the watchdog mode bit, and from the watchdog interrupt enable. A hardware reset returns the block to run at once and raises the internal reset. No RAM-clear indication exists, so RAM contents survive every kind of wake.

Top module: `stw_seq`

## Requirements
- R1: In RUN (state 0), a cycle with `stop_req`=1 and `rcwdt_sel`=1 moves the block to STOPPED (state 1) at the next clock edge. In STOPPED, `osc_en`=0, `core_clk_en`=0 and `hold_ports`=1.
- R2: A cycle with `stop_req`=1 and `rcwdt_sel`=0 leaves the block in RUN, with `osc_en`=1 and `core_clk_en`=1.
- R3: STOPPED is left only on `ext_irq`=1 or `ext_rst`=1. A `wdt_event` while stopped is recorded but does not wake the block.
- R4: `ext_rst`=1 in any state puts the block in RUN at the next edge with `int_reset`=1 for one cycle, and discards any recorded watchdog event.
- R5: An `ext_irq` in STOPPED moves the block to STABILIZING (state 2). In that state `osc_en`=1, `core_clk_en`=0 and `hold_ports`=1. The counter starts at 0x00 and steps once every 2^`div_sel` prescaled ticks, with `div_sel` latched at stop entry. The step that overflows 0xFF moves the block to RESUME (state 3).
- R6: RESUME lasts exactly one cycle, with `resume_pulse`=1 and `core_clk_en`=1, and then returns to RUN. The `resume_action` encoding is 0 fall-through, 1 interrupt vector, 2 watchdog vector, 3 internal reset.
- R7: If `gie`=0 at the overflow step, `resume_action` is 0.
- R8: If `gie`=1 and no watchdog event was seen since stop entry, `resume_action` is 1.
- R9: If `gie`=1, a watchdog event was seen and `wdt_mode`=0: `resume_action` is 2 when `wdt_irq_en`=1, and 1 when `wdt_irq_en`=0.
- R10: If `gie`=1, a watchdog event was seen and `wdt_mode`=1: `resume_action` is 3, and `int_reset`=1 in the same cycle as `resume_pulse`.
- R11: An `ext_irq` during STABILIZING neither restarts nor shortens the counter. It is serviced by the resume that follows the overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous register reset |
| ext_rst | input | 1 | External hardware reset event |
| stop_req | input | 1 | Stop request from the core |
| rcwdt_sel | input | 1 | RC-watchdog stop-mode select |
| div_sel | input | DIV_W | Prescale ratio exponent, latched at stop entry |
| presc_tick | input | 1 | Prescaled tick from the RC domain |
| ext_irq | input | 1 | External interrupt |
| wdt_event | input | 1 | Watchdog timeout event |
| gie | input | 1 | Global interrupt enable flag |
| wdt_mode | input | 1 | Watchdog mode: 1 = reset, 0 = interrupt |
| wdt_irq_en | input | 1 | Watchdog interrupt enable |
| osc_en | output | 1 | Main oscillator enable |
| core_clk_en | output | 1 | Core clock gate enable |
| hold_ports | output | 1 | Freeze port data and direction registers |
| state | output | 2 | 0 RUN, 1 STOPPED, 2 STABILIZING, 3 RESUME |
| resume_pulse | output | 1 | One-cycle resume strobe |
| resume_action | output | 2 | Resume action code, valid with resume_pulse |
| int_reset | output | 1 | Internal reset request |

## Verification
A behavioural reference model follows every cycle across a set of stop and wake rounds. The rounds cover the four flag combinations that select the action code, so a mixed-up priority among the global flag, the mode bit and the enable produces a wrong code. One round changes the ratio input after entry and another toggles the prescaled tick, which separates a latched ratio from a live one and ticks from clock cycles. Further rounds send stray interrupts during stabilization, watchdog events and ignored stop requests, and a reset in the middle of stabilization. These show whether the counter restarts, whether the block wakes on the wrong event, and whether a stale watchdog record leaks into the next round.

// File: rtl/stw_pkg.sv
package stw_pkg;
   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_STOP   = 2'd1,
      ST_STAB   = 2'd2,
      ST_RESUME = 2'd3
   } stw_state_e;

   typedef enum logic [1:0] {
      ACT_FALL = 2'd0,
      ACT_IRQ  = 2'd1,
      ACT_WDT  = 2'd2,
      ACT_RST  = 2'd3
   } stw_act_e;
endpackage

// File: rtl/stw_tickdiv.sv
module stw_tickdiv #(
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIV_W-1:0] div_in,
   input  logic             en,
   input  logic             tick,
   output logic             step
);
   localparam int SUB_W = (1 << DIV_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [SUB_W-1:0] sub_q;
   logic [SUB_W-1:0] lim;
   logic             last;

   assign lim  = ~({SUB_W{1'b1}} << div_q);
   assign last = (sub_q == lim);
   assign step = en & tick & last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         sub_q <= '0;
      end else begin
         if (load) div_q <= div_in;
         if (!en)
            sub_q <= '0;
         else if (tick)
            sub_q <= last ? '0 : sub_q + 1'b1;
      end
   end
endmodule

// File: rtl/stw_stabcnt.sv
module stw_stabcnt #(
   parameter int CNT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic ovf
);
   logic [CNT_W-1:0] cnt_q;

   assign ovf = step & (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (step)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/stw_actsel.sv
module stw_actsel
   import stw_pkg::*;
(
   input  logic     gie,
   input  logic     wdt_seen,
   input  logic     wdt_mode,
   input  logic     wdt_irq_en,
   output stw_act_e act
);
   always_comb begin
      if (!gie)
         act = ACT_FALL;
      else if (!wdt_seen)
         act = ACT_IRQ;
      else if (wdt_mode)
         act = ACT_RST;
      else if (wdt_irq_en)
         act = ACT_WDT;
      else
         act = ACT_IRQ;
   end
endmodule

// File: rtl/stw_seq.sv
module stw_seq
   import stw_pkg::*;
#(
   parameter int DIV_W = 2,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_rst,
   input  logic             stop_req,
   input  logic             rcwdt_sel,
   input  logic [DIV_W-1:0] div_sel,
   input  logic             presc_tick,
   input  logic             ext_irq,
   input  logic             wdt_event,
   input  logic             gie,
   input  logic             wdt_mode,
   input  logic             wdt_irq_en,
   output logic             osc_en,
   output logic             core_clk_en,
   output logic             hold_ports,
   output logic [1:0]       state,
   output logic             resume_pulse,
   output logic [1:0]       resume_action,
   output logic             int_reset
);
   generate
      if (DIV_W < 1 || DIV_W > 3) begin : g_bad_div
         $error("stw_seq: DIV_W must lie in 1..3");
      end
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("stw_seq: CNT_W must lie in 2..16");
      end
   endgenerate

   stw_state_e st_q, st_d;
   stw_act_e   act_q, act_sel;
   logic       pend_q, irst_q;
   logic       enter_stop, in_stab, step, ovf, wdt_seen, fire;

   assign in_stab    = (st_q == ST_STAB);
   assign enter_stop = (st_q == ST_RUN) & stop_req & rcwdt_sel & ~ext_rst;
   assign wdt_seen   = pend_q | wdt_event;
   assign fire       = in_stab & ovf & ~ext_rst;

   stw_tickdiv #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (enter_stop),
      .div_in (div_sel),
      .en     (in_stab),
      .tick   (presc_tick),
      .step   (step)
   );

   stw_stabcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (~in_stab),
      .step  (step),
      .ovf   (ovf)
   );

   stw_actsel u_act (
      .gie        (gie),
      .wdt_seen   (wdt_seen),
      .wdt_mode   (wdt_mode),
      .wdt_irq_en (wdt_irq_en),
      .act        (act_sel)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RUN:    if (stop_req && rcwdt_sel) st_d = ST_STOP;
         ST_STOP:   if (ext_irq)               st_d = ST_STAB;
         ST_STAB:   if (ovf)                   st_d = ST_RESUME;
         ST_RESUME:                            st_d = ST_RUN;
         default:                              st_d = ST_RUN;
      endcase
      if (ext_rst) st_d = ST_RUN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_RUN;
         act_q  <= ACT_FALL;
         pend_q <= 1'b0;
         irst_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         irst_q <= ext_rst | (fire & (act_sel == ACT_RST));
         if (fire) act_q <= act_sel;
         if (ext_rst || enter_stop)
            pend_q <= 1'b0;
         else if (wdt_event && (st_q == ST_STOP || in_stab))
            pend_q <= 1'b1;
      end
   end

   assign osc_en        = (st_q != ST_STOP);
   assign core_clk_en   = (st_q == ST_RUN) | (st_q == ST_RESUME);
   assign hold_ports    = (st_q == ST_STOP) | in_stab;
   assign state         = st_q;
   assign resume_pulse  = (st_q == ST_RESUME);
   assign resume_action = act_q;
   assign int_reset     = irst_q;
endmodule

// File: rtl/stw_checker.sv
module stw_checker #(
   parameter int DIV_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ext_rst,
   input logic             stop_req,
   input logic             rcwdt_sel,
   input logic [DIV_W-1:0] div_sel,
   input logic             ext_irq,
   input logic             gie,
   input logic             osc_en,
   input logic             core_clk_en,
   input logic             hold_ports,
   input logic [1:0]       state,
   input logic             resume_pulse,
   input logic [1:0]       resume_action,
   input logic             int_reset
);
   a_r1_enter_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd0 && stop_req && rcwdt_sel && !ext_rst) |=> (state == 2'd1));

   a_r1_stopped_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd1) |-> (!osc_en && !core_clk_en && hold_ports));

   a_r2_ignore_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd0 && stop_req && !rcwdt_sel && !ext_rst) |=> (state == 2'd0));

   a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd1 && !ext_irq && !ext_rst) |=> (state == 2'd1));

   a_r4_hw_reset: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rst |=> (state == 2'd0 && int_reset));

   a_r5_stab_clock_off: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd2) |-> (osc_en && !core_clk_en));

   a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      resume_pulse |=> (!resume_pulse && state == 2'd0));

   a_r7_no_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (resume_pulse && !$past(gie)) |-> (resume_action == 2'd0));

   a_r10_reset_action: assert property (@(posedge clk) disable iff (!rst_n)
      (resume_pulse && resume_action == 2'd3) |-> int_reset);

   a_r11_pulse_from_stab: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(resume_pulse) |-> ($past(state) == 2'd2));
endmodule

bind stw_seq stw_checker #(.DIV_W(DIV_W)) u_stw_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ext_rst       (ext_rst),
   .stop_req      (stop_req),
   .rcwdt_sel     (rcwdt_sel),
   .div_sel       (div_sel),
   .ext_irq       (ext_irq),
   .gie           (gie),
   .osc_en        (osc_en),
   .core_clk_en   (core_clk_en),
   .hold_ports    (hold_ports),
   .state         (state),
   .resume_pulse  (resume_pulse),
   .resume_action (resume_action),
   .int_reset     (int_reset)
);

// File: tb/stw_seq_bench.sv
`timescale 1ns/1ps
module stw_seq_bench;
   localparam int DIV_W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_rst = 0, stop_req = 0, rcwdt_sel = 0, presc_tick = 0;
   logic ext_irq = 0, wdt_event = 0, gie = 0, wdt_mode = 0, wdt_irq_en = 0;
   logic [DIV_W-1:0] div_sel = '0;
   logic osc_en, core_clk_en, hold_ports, resume_pulse, int_reset;
   logic [1:0] state, resume_action;

   always #5 clk = ~clk;

   stw_seq #(.DIV_W(DIV_W), .CNT_W(8)) u_stw_seq (
      .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .stop_req(stop_req),
      .rcwdt_sel(rcwdt_sel), .div_sel(div_sel), .presc_tick(presc_tick),
      .ext_irq(ext_irq), .wdt_event(wdt_event), .gie(gie), .wdt_mode(wdt_mode),
      .wdt_irq_en(wdt_irq_en), .osc_en(osc_en), .core_clk_en(core_clk_en),
      .hold_ports(hold_ports), .state(state), .resume_pulse(resume_pulse),
      .resume_action(resume_action), .int_reset(int_reset)
   );

   int checks = 0;
   int failures = 0;
   string tag = "R6";
   int tick_mode = 0;   // 0: every cycle, 1: every other cycle
   int phase = 0;

   // Reference model
   int m_state = 0, m_cnt = 0, m_sub = 0, m_div = 0, m_pend = 0, m_act = 0, m_irst = 0;

   always @(negedge clk) begin
      phase <= phase + 1;
      presc_tick <= (tick_mode == 0) ? 1'b1 : phase[0];
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state <= 0; m_cnt <= 0; m_sub <= 0; m_div <= 0;
         m_pend <= 0; m_act <= 0; m_irst <= 0;
      end else begin
         int ns, np, a;
         ns = m_state; np = m_pend;
         m_irst <= 0;
         if (ext_rst) begin
            ns = 0; np = 0; m_irst <= 1;
         end else begin
            case (m_state)
               0: if (stop_req && rcwdt_sel) begin
                     ns = 1; np = 0; m_div <= div_sel; m_cnt <= 0; m_sub <= 0;
                  end
               1: begin
                     if (wdt_event) np = 1;
                     if (ext_irq) begin ns = 2; m_cnt <= 0; m_sub <= 0; end
                  end
               2: begin
                     if (wdt_event) np = 1;
                     if (presc_tick) begin
                        if (m_sub == (1 << m_div) - 1) begin
                           m_sub <= 0;
                           if (m_cnt == 255) begin
                              if (!gie) a = 0;
                              else if (np == 0) a = 1;
                              else if (wdt_mode) a = 3;
                              else if (wdt_irq_en) a = 2;
                              else a = 1;
                              m_act <= a;
                              if (a == 3) m_irst <= 1;
                              ns = 3; m_cnt <= 0;
                           end else m_cnt <= m_cnt + 1;
                        end else m_sub <= m_sub + 1;
                     end
                  end
               default: ns = 0;
            endcase
         end
         m_state <= ns; m_pend <= np;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(tag, "state", state, m_state);
         chk(tag, "osc_en", osc_en, (m_state != 1));
         chk(tag, "core_clk_en", core_clk_en, (m_state == 0 || m_state == 3));
         chk(tag, "hold_ports", hold_ports, (m_state == 1 || m_state == 2));
         chk(tag, "resume_pulse", resume_pulse, (m_state == 3));
         chk(tag, "int_reset", int_reset, m_irst);
         if (m_state == 3) chk(tag, "resume_action", resume_action, m_act);
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic enter_stop(input int d);
      div_sel = d[DIV_W-1:0]; rcwdt_sel = 1; stop_req = 1;
      cyc(1);
      stop_req = 0;
   endtask

   // Wake and count cycles until the resume pulse; check latency and action.
   task automatic wake_and_check(input string req, input int exp_cycles, input int exp_act,
                                 input bit stray_irq);
      int k;
      ext_irq = 1;
      cyc(1);
      ext_irq = 0;
      k = 1;
      while (!resume_pulse && k < 5000) begin
         if (stray_irq && k == 40) ext_irq = 1;
         else ext_irq = 0;
         cyc(1); k++;
      end
      ext_irq = 0;
      chk(req, "wake latency", k, exp_cycles);
      chk(req, "action code", resume_action, exp_act);
      if (exp_act == 3) chk(req, "int_reset at pulse", int_reset, 1);
      cyc(1);
      chk(req, "back in RUN", state, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(1);
      tag = "R6";
      chk("R6", "reset state RUN", state, 0);
      chk("R6", "reset clock enabled", core_clk_en, 1);

      // R2: unselected stop request ignored
      tag = "R2";
      rcwdt_sel = 0; stop_req = 1; cyc(1); stop_req = 0; cyc(3);
      chk("R2", "stay RUN", state, 0);
      chk("R2", "osc on", osc_en, 1);

      // R1, R5, R8: plain wake, gie=1, no watchdog
      tag = "R1"; gie = 1;
      enter_stop(0);
      chk("R1", "stopped", state, 1);
      chk("R1", "osc off", osc_en, 0);
      cyc(10);
      tag = "R8";
      wake_and_check("R8", 257, 1, 0);

      // R7: gie=0 falls through
      tag = "R7"; gie = 0;
      enter_stop(0); cyc(4);
      wake_and_check("R7", 257, 0, 0);

      // R3, R9: watchdog events while stopped, no wake; mode 0
      tag = "R3"; gie = 1; wdt_mode = 0; wdt_irq_en = 1;
      enter_stop(0);
      wdt_event = 1; cyc(1); wdt_event = 0; cyc(5);
      chk("R3", "watchdog does not wake", state, 1);
      tag = "R9";
      wake_and_check("R9", 257, 2, 0);

      tag = "R9"; wdt_irq_en = 0;
      enter_stop(0); cyc(2);
      wdt_event = 1; cyc(1); wdt_event = 0;
      wake_and_check("R9", 257, 1, 0);

      // R10: watchdog in reset mode
      tag = "R10"; wdt_mode = 1; wdt_irq_en = 1;
      enter_stop(0); cyc(2);
      wdt_event = 1; cyc(1); wdt_event = 0;
      wake_and_check("R10", 257, 3, 0);

      // R4: stale watchdog record is cleared by new entry, hw reset mid-stabilize
      tag = "R4";
      enter_stop(0);
      ext_irq = 1; cyc(1); ext_irq = 0; cyc(20);
      chk("R4", "stabilizing", state, 2);
      ext_rst = 1; cyc(1); ext_rst = 0;
      chk("R4", "reset to RUN", state, 0);
      chk("R4", "internal reset", int_reset, 1);
      cyc(1);
      chk("R4", "internal reset one cycle", int_reset, 0);

      // R11: stray interrupt during stabilization
      tag = "R11"; wdt_mode = 0;
      enter_stop(0); cyc(3);
      wake_and_check("R11", 257, 1, 1);

      // R5: ratio latched at entry, changed afterwards; slow ticks
      tag = "R5";
      enter_stop(1);
      div_sel = 2'd3;
      cyc(2);
      wake_and_check("R5", 513, 1, 0);
      tick_mode = 1;
      enter_stop(0); cyc(2);
      wake_and_check("R5", 512, 1, 0);
      tick_mode = 0;
      cyc(4);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule